// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers level-sensitive interrupt request lines from devices and presents a single interrupt request to a processor. A line that is high and not masked is a pending request. When one or more are pending and the controller is idle, the lowest-numbered request wins. The controller then stores an 8-bit vector, formed by adding the winning line's index to a programmable base, in a register the processor reads, and it raises `intr_o`. The request stays raised until the processor returns a one-cycle acknowledge. The controller then drops `intr_o` and goes back to scanning its lines.

Two identical units are built in a cascade. A secondary unit serves its own eight lines, and its interrupt output replaces primary line 2. When line 2 wins at the primary, the primary passes on the vector the secondary has already latched. The processor's acknowledge clears both units. A small write port sets the base offset and the mask of each unit.

Top module: `vic_cascade_top`

## Requirements
- R1: After reset `intr_o` is 0 and `vector_o` is 0. Both base offsets are 32 and both masks are 0.
- R2: A line is pending while it is high. Among pending, unmasked lines the lowest index wins.
- R3: The vector of a non-cascade win is (base + line index) modulo 256.
- R4: If the unit is idle and has an eligible line at a clock edge, `intr_o` is 1 and `vector_o` holds the new vector right after that edge.
- R5: `intr_o` stays 1 until a cycle in which `ack_i` is 1. It is 0 after that edge, and scanning resumes at the following edge.
- R6: While `intr_o` is 1, `vector_o` does not change. This holds even if a lower-numbered line rises or the base is rewritten.
- R7: A line whose mask bit (bit i for line i) is 1 takes no part in selection, in either unit.
- R8: An `ack_i` pulse while `intr_o` is 0 has no effect. Requests that arrive later are served normally.
- R9: Primary line 2 is driven by the secondary's interrupt output, and `req_i[2]` is ignored. When line 2 wins, `vector_o` equals the secondary's vector. The acknowledge of that win also clears the secondary.
- R10: On `wr_en_i`, `wr_data_i` goes to the register chosen by `wr_sel_i`: 0 selects the primary base, 1 the primary mask, 2 the secondary base and 3 the secondary mask. The new value takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Primary request lines (bit 2 unused) |
| sec_req_i | input | 8 | Secondary request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | 8 | Write data |
| ack_i | input | 1 | One-cycle acknowledge from the processor |
| intr_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Latched vector |

## Verification
A direct request shows up on `intr_o` and `vector_o` one edge after it is sampled. A secondary request needs two edges: the secondary latches first, and the primary picks it up at the next edge. An acknowledge clears `intr_o` at the edge that samples it. The bench drives inputs on falling edges and compares the outputs against a behavioural model on every falling edge, so every result is read half a cycle after the edge that produced it. Directed checks are placed after a counted number of edges that matches these latencies.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned VIC_LINES    = 8;
  localparam int unsigned VIC_VEC_W    = 8;
  localparam int unsigned VIC_BASE_RST = 32;
  localparam int unsigned VIC_CAS_LINE = 2;

  typedef enum logic [1:0] {
    SEL_PRI_BASE = 2'd0,
    SEL_PRI_MASK = 2'd1,
    SEL_SEC_BASE = 2'd2,
    SEL_SEC_MASK = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/vic_lowest_pick.sv
module vic_lowest_pick #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] elig_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_unit.sv
module vic_unit #(
  parameter int unsigned N_LINES  = vic_pkg::VIC_LINES,
  parameter int unsigned VEC_W    = vic_pkg::VIC_VEC_W,
  parameter int unsigned BASE_RST = vic_pkg::VIC_BASE_RST,
  parameter bit          CAS_EN   = 1'b0,
  parameter int unsigned CAS_LINE = vic_pkg::VIC_CAS_LINE,
  localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic               base_we_i,
  input  logic               mask_we_i,
  input  logic [VEC_W-1:0]   wdata_i,
  input  logic [VEC_W-1:0]   cas_vec_i,
  input  logic               ack_i,
  output logic               intr_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [IDX_W-1:0]   win_o
);
  logic [VEC_W-1:0]   base_q;
  logic [N_LINES-1:0] mask_q;
  logic               pend_q;
  logic [VEC_W-1:0]   vec_q;
  logic [IDX_W-1:0]   win_q;
  logic [N_LINES-1:0] elig;
  logic               found;
  logic [IDX_W-1:0]   idx;
  logic [VEC_W-1:0]   vec_d;

  assign elig = req_i & ~mask_q;

  vic_lowest_pick #(.N_LINES(N_LINES)) u_pick (
    .elig_i (elig),
    .found_o(found),
    .idx_o  (idx)
  );

  always_comb begin
    vec_d = base_q + VEC_W'(idx);
    if (CAS_EN && (idx == IDX_W'(CAS_LINE))) vec_d = cas_vec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= VEC_W'(BASE_RST);
      mask_q <= '0;
    end else begin
      if (base_we_i) base_q <= wdata_i;
      if (mask_we_i) mask_q <= wdata_i[N_LINES-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
      win_q  <= '0;
    end else if (pend_q) begin
      if (ack_i) pend_q <= 1'b0;
    end else if (found) begin
      pend_q <= 1'b1;
      vec_q  <= vec_d;
      win_q  <= idx;
    end
  end

  assign intr_o = pend_q;
  assign vec_o  = vec_q;
  assign win_o  = win_q;

  assert_lowest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> (elig[idx] && ((elig & ((N_LINES'(1) << idx) - N_LINES'(1))) == '0)));
  assert_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> !mask_q[idx]);
  assert_raise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && found) |=> pend_q);
  assert_ack_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && ack_i) |=> !pend_q);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_i) |=> (pend_q && $stable(vec_q) && $stable(win_q)));
  assert_idle_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && ack_i && !found) |=> (!pend_q && $stable(vec_q)));
endmodule

// File: rtl/vic_cascade_top.sv
module vic_cascade_top
  import vic_pkg::*;
#(
  parameter int unsigned N_LINES  = VIC_LINES,
  parameter int unsigned VEC_W    = VIC_VEC_W,
  parameter int unsigned BASE_RST = VIC_BASE_RST,
  parameter int unsigned CAS_LINE = VIC_CAS_LINE,
  localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] sec_req_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [VEC_W-1:0]   wr_data_i,
  input  logic               ack_i,
  output logic               intr_o,
  output logic [VEC_W-1:0]   vector_o
);
  logic               sec_intr;
  logic [VEC_W-1:0]   sec_vec;
  logic [IDX_W-1:0]   sec_win;
  logic [IDX_W-1:0]   pri_win;
  logic [N_LINES-1:0] pri_req;
  logic               pri_cas_win;
  logic               sec_ack;
  logic [3:0]         we;

  always_comb begin
    we = '0;
    if (wr_en_i) we[wr_sel_i] = 1'b1;
  end

  always_comb begin
    pri_req           = req_i;
    pri_req[CAS_LINE] = sec_intr;
  end

  assign pri_cas_win = intr_o && (pri_win == IDX_W'(CAS_LINE));
  assign sec_ack     = ack_i && pri_cas_win;

  vic_unit #(
    .N_LINES(N_LINES), .VEC_W(VEC_W), .BASE_RST(BASE_RST),
    .CAS_EN(1'b0), .CAS_LINE(CAS_LINE)
  ) u_sec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (sec_req_i),
    .base_we_i(we[SEL_SEC_BASE]),
    .mask_we_i(we[SEL_SEC_MASK]),
    .wdata_i  (wr_data_i),
    .cas_vec_i('0),
    .ack_i    (sec_ack),
    .intr_o   (sec_intr),
    .vec_o    (sec_vec),
    .win_o    (sec_win)
  );

  vic_unit #(
    .N_LINES(N_LINES), .VEC_W(VEC_W), .BASE_RST(BASE_RST),
    .CAS_EN(1'b1), .CAS_LINE(CAS_LINE)
  ) u_pri (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (pri_req),
    .base_we_i(we[SEL_PRI_BASE]),
    .mask_we_i(we[SEL_PRI_MASK]),
    .wdata_i  (wr_data_i),
    .cas_vec_i(sec_vec),
    .ack_i    (ack_i),
    .intr_o   (intr_o),
    .vec_o    (vector_o),
    .win_o    (pri_win)
  );

  assert_cas_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(intr_o) && pri_cas_win) |-> (vector_o == $past(sec_vec)));
  assert_cas_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pri_cas_win) |=> !sec_intr);
  assert_sec_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_intr && !sec_ack) |=> (sec_intr && $stable(sec_vec) && $stable(sec_win)));
endmodule

// File: tb/vic_cascade_top_bench.sv
module vic_cascade_top_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req_i = '0;
  logic [7:0] sec_req_i = '0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       ack_i = 1'b0;
  logic       intr_o;
  logic [7:0] vector_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  vic_cascade_top u_vic_cascade_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .sec_req_i(sec_req_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .ack_i(ack_i), .intr_o(intr_o), .vector_o(vector_o)
  );

  // behavioural reference model
  int m_pbase, m_pmask, m_sbase, m_smask;
  int m_ppend, m_spend, m_pvec, m_svec, m_pwin;

  function automatic int lowest(input int v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pbase = 32; m_sbase = 32; m_pmask = 0; m_smask = 0;
      m_ppend = 0; m_spend = 0; m_pvec = 0; m_svec = 0; m_pwin = 0;
    end else begin
      int s_el, p_el, sw, pw, n_spend, n_svec, n_ppend, n_pvec, n_pwin;
      s_el = int'(sec_req_i) & ~m_smask & 255;
      p_el = ((int'(req_i) & ~4) | (m_spend << 2)) & ~m_pmask & 255;
      sw = lowest(s_el);
      pw = lowest(p_el);
      n_spend = m_spend; n_svec = m_svec;
      n_ppend = m_ppend; n_pvec = m_pvec; n_pwin = m_pwin;
      if (m_spend != 0) begin
        if (ack_i && m_ppend != 0 && m_pwin == 2) n_spend = 0;
      end else if (sw >= 0) begin
        n_spend = 1; n_svec = (m_sbase + sw) % 256;
      end
      if (m_ppend != 0) begin
        if (ack_i) n_ppend = 0;
      end else if (pw >= 0) begin
        n_ppend = 1; n_pwin = pw;
        n_pvec = (pw == 2) ? m_svec : (m_pbase + pw) % 256;
      end
      m_spend = n_spend; m_svec = n_svec;
      m_ppend = n_ppend; m_pvec = n_pvec; m_pwin = n_pwin;
      if (wr_en_i) begin
        case (wr_sel_i)
          2'd0: m_pbase = int'(wr_data_i);
          2'd1: m_pmask = int'(wr_data_i);
          2'd2: m_sbase = int'(wr_data_i);
          default: m_smask = int'(wr_data_i);
        endcase
      end
    end
  end

  // every-cycle comparison, half a cycle after each edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (intr_o !== m_ppend[0]) begin
        errors++;
        $display("FAIL R5 intr_o actual %0b expected %0b", intr_o, m_ppend[0]);
      end
      checks++;
      if (vector_o !== 8'(m_pvec)) begin
        errors++;
        $display("FAIL R3 vector_o actual %0d expected %0d", vector_o, m_pvec);
      end
    end
  end

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic expect_out(input logic i_exp, input int v_exp, input string tag);
    checks++;
    if (intr_o !== i_exp || vector_o !== 8'(v_exp)) begin
      errors++;
      $display("FAIL %s intr/vector actual %0b/%0d expected %0b/%0d",
               tag, intr_o, vector_o, i_exp, v_exp);
    end
  endtask

  task automatic expect_intr(input logic i_exp, input string tag);
    checks++;
    if (intr_o !== i_exp) begin
      errors++;
      $display("FAIL %s intr actual %0b expected %0b", tag, intr_o, i_exp);
    end
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1; step(); ack_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d; step(); wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    expect_out(1'b0, 0, "R1");

    // R4 / R3: line 4 with reset base 32
    req_i = 8'h10; step();
    expect_out(1'b1, 36, "R4");
    // R6: lower line rises and base is rewritten while pending
    req_i = 8'h11; step();
    expect_out(1'b1, 36, "R6");
    wr(2'd0, 8'd64);
    expect_out(1'b1, 36, "R6");
    pulse_ack();
    expect_intr(1'b0, "R5");
    step();
    expect_out(1'b1, 64, "R2");      // line 0 wins, new base (R10)
    req_i = 8'h00; pulse_ack(); step();
    expect_intr(1'b0, "R5");

    // R7: mask line 0
    wr(2'd1, 8'h01);
    req_i = 8'h11; step();
    expect_out(1'b1, 68, "R7");
    req_i = 8'h00; pulse_ack(); step();
    wr(2'd1, 8'h00);

    // R8: acknowledge while idle
    pulse_ack();
    expect_out(1'b0, 68, "R8");
    req_i = 8'h80; step();
    expect_out(1'b1, 71, "R8");
    req_i = 8'h00; pulse_ack(); step();

    // R9: req_i[2] ignored, secondary feeds line 2
    req_i = 8'h04; step(); step();
    expect_intr(1'b0, "R9");
    req_i = 8'h00;
    wr(2'd2, 8'h70);
    sec_req_i = 8'h20; step();
    expect_intr(1'b0, "R9");
    step();
    expect_out(1'b1, 8'h75, "R9");
    sec_req_i = 8'h00; pulse_ack();
    expect_intr(1'b0, "R9");
    step();
    expect_intr(1'b0, "R9");

    // R2 with cascade: line 1 beats line 2
    req_i = 8'h02; sec_req_i = 8'h01; step();
    expect_out(1'b1, 65, "R2");
    req_i = 8'h00; pulse_ack(); step();
    expect_out(1'b1, 8'h70, "R9");
    sec_req_i = 8'h00; pulse_ack(); step();
    expect_intr(1'b0, "R9");

    // R3: wraparound
    wr(2'd0, 8'hFC);
    req_i = 8'h80; step();
    expect_out(1'b1, 3, "R3");
    req_i = 8'h00; pulse_ack(); step();

    // R10 / R7: secondary mask
    wr(2'd3, 8'h01);
    sec_req_i = 8'h03; step(); step();
    expect_out(1'b1, 8'h71, "R10");
    sec_req_i = 8'h00; pulse_ack(); step();
    expect_intr(1'b0, "R7");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule